// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This block drives a one-time-programmable memory through a complete programming run, one word at a time. It fetches each word from an image port, gives it timed program pulses, checks the device with verify reads, and issues a single pass/fail verdict. The memory is reached through an abstract word interface: an address, write data, a program-pulse strobe, a read strobe with one cycle of read latency, and a two-bit request for the supply level.

A run starts with a contact check at equal program and main supply levels. A full program pass follows, giving each word exactly one pulse. Whole-array verify passes come next; a word that reads wrong gets one more pulse, and the number of these re-pulse passes has a limit. The run ends with a read-back of the whole array at the normal read supply. The pulse width is derived from the clock frequency and the nominal pulse time, both of which are parameters, as is the number of words.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, and while no run is active, busy, done, pass, dev_pgm and dev_rd are low, dev_supply is 00 (read level) and fail_addr is 0.
- R2: A start pulse opens a contact check at dev_supply 01 (program level equal to main supply). The block reads the address of alternating bits with bit 0 set (5 for four address bits) and expects CHK_CODE (default 16'h55AA). It then reads the bitwise complement of that address (10) and expects ~CHK_CODE (16'hAA55). Each read holds dev_rd high for one cycle and takes dev_rdata in the following cycle.
- R3: A contact-check read that does not match ends the run with done high, pass low and fail_addr set to the address of that check, before any program pulse.
- R4: The first program pass gives exactly one pulse to every word, in ascending order from 0 to WORDS-1. dev_supply is 10 (program level) while dev_pgm is high, and dev_pgm is never high together with dev_rd.
- R5: Every program pulse lasts exactly CLK_MHZ*PULSE_NS/1000 clock cycles.
- R6: dev_addr does not change while dev_pgm is high, nor in the cycle after dev_pgm falls.
- R7: Verify passes read every word in ascending order at dev_supply 10. A word that mismatches gets one extra pulse at once, and the pass then continues. If any word mismatched, the whole verify pass repeats, up to RETRY_LIM re-pulse passes.
- R8: A verify mismatch found after RETRY_LIM re-pulse passes ends the run as a failure, with fail_addr set to that word and no further pulse.
- R9: Once verify is clean, the block reads every word again at dev_supply 00. The first mismatch fails the run with its address. A full match sets pass high.
- R10: busy is high from the cycle after an accepted start until the verdict. done and the verdict then hold until the next start, and done never coincides with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when not busy) |
| img_addr | output | AW | Image read address (equals dev_addr) |
| img_data | input | DW | Image word at img_addr, same cycle |
| dev_addr | output | AW | Memory word address |
| dev_wdata | output | DW | Data to program |
| dev_pgm | output | 1 | Program pulse strobe |
| dev_rd | output | 1 | Read strobe, data returns next cycle |
| dev_rdata | input | DW | Read data from memory |
| dev_supply | output | 2 | Supply request: 00 read, 01 equal, 10 program |
| busy | output | 1 | Run in progress |
| done | output | 1 | Verdict available |
| pass | output | 1 | Device programmed and read back correctly |
| fail_addr | output | AW | Address of the first error |

## Verification
The hardest condition to reach from the ports is the retry limit. A word must stay wrong through the first pass and through two re-pulse passes, while other words recover after one or two extra pulses. The bench device model attaches to each word the number of pulses it needs before it reads correctly, and a scoreboard predicts the exact order of pulse addresses across all passes. Marginal words that read correctly at program level but wrong at read level show whether the final read-back really runs at the lowered supply.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [1:0] {
        SUP_READ  = 2'b00,
        SUP_EQUAL = 2'b01,
        SUP_PROG  = 2'b10
    } supply_t;

    typedef enum logic [1:0] {
        W_HOLD,
        W_CLR,
        W_INC,
        W_LOAD
    } walk_op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CC_RD,
        S_CC_CMP,
        S_P_SETUP,
        S_P_PULSE,
        S_P_HOLD,
        S_V_RD,
        S_V_CMP,
        S_F_RD,
        S_F_CMP,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic second_chk;   // contact check on complementary pattern
        logic dirty;        // a word mismatched in this verify pass
        logic repulse;      // current pulse belongs to a verify pass
    } seq_flags_t;

    localparam logic [63:0] ALT_BITS = {32{2'b01}};

    function automatic int pulse_cycles(input int mhz, input int ns);
        int c;
        c = (mhz * ns) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
    parameter int CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/otp_addr_walker.sv
module otp_addr_walker
    import otp_seq_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  walk_op_t      op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] TOP = AW'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else begin
            case (op)
                W_CLR:   addr <= '0;
                W_INC:   addr <= addr + 1'b1;
                W_LOAD:  addr <= load_val;
                default: addr <= addr;
            endcase
        end
    end

    assign last = (addr == TOP);
endmodule

// File: rtl/otp_word_cmp.sv
module otp_word_cmp #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] got,
    input  logic [DW-1:0] want,
    output logic          match
);
    logic [DW-1:0] diff;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign diff[b] = got[b] ^ want[b];
    end

    assign match = ~|diff;
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int          WORDS     = 16,
    parameter int          AW        = $clog2(WORDS),
    parameter int          DW        = 16,
    parameter int          CLK_MHZ   = 200,
    parameter int          PULSE_NS  = 10000,
    parameter int          RETRY_LIM = 2,
    parameter logic [DW-1:0] CHK_CODE = 16'h55AA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [AW-1:0] img_addr,
    input  logic [DW-1:0] img_data,
    output logic [AW-1:0] dev_addr,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_pgm,
    output logic          dev_rd,
    input  logic [DW-1:0] dev_rdata,
    output logic [1:0]    dev_supply,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr
);
    localparam int            PULSE_CYC = pulse_cycles(CLK_MHZ, PULSE_NS);
    localparam int            XW        = $clog2(RETRY_LIM + 1);
    localparam logic [AW-1:0] PAT_A     = ALT_BITS[AW-1:0];
    localparam logic [AW-1:0] PAT_B     = ~PAT_A;
    localparam logic [XW-1:0] X_LIM     = XW'(RETRY_LIM);

    seq_state_t    state, state_n;
    supply_t       sup, sup_n;
    seq_flags_t    flg, flg_n;
    logic [XW-1:0] x_cnt, x_n;
    walk_op_t      op;
    logic [AW-1:0] load_val;
    logic [AW-1:0] addr;
    logic          last;
    logic          expired;
    logic          match;
    logic [DW-1:0] want;
    logic          adv;
    logic          fin_fail;
    logic          fin_pass;
    logic          accept;

    otp_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == S_P_PULSE),
        .expired (expired)
    );

    otp_addr_walker #(.WORDS(WORDS), .AW(AW)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (load_val),
        .addr     (addr),
        .last     (last)
    );

    assign want = (state == S_CC_CMP) ? (flg.second_chk ? ~CHK_CODE : CHK_CODE)
                                      : img_data;

    otp_word_cmp #(.DW(DW)) u_cmp (
        .got   (dev_rdata),
        .want  (want),
        .match (match)
    );

    assign accept = start && ((state == S_IDLE) || (state == S_DONE));

    always_comb begin
        state_n  = state;
        sup_n    = sup;
        flg_n    = flg;
        x_n      = x_cnt;
        op       = W_HOLD;
        load_val = PAT_A;
        adv      = 1'b0;
        fin_fail = 1'b0;
        fin_pass = 1'b0;

        case (state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_n          = S_CC_RD;
                    op               = W_LOAD;
                    load_val         = PAT_A;
                    sup_n            = SUP_EQUAL;
                    flg_n.second_chk = 1'b0;
                end
            end
            S_CC_RD:  state_n = S_CC_CMP;
            S_CC_CMP: begin
                if (!match) begin
                    fin_fail = 1'b1;
                end else if (!flg.second_chk) begin
                    flg_n.second_chk = 1'b1;
                    op               = W_LOAD;
                    load_val         = PAT_B;
                    state_n          = S_CC_RD;
                end else begin
                    op            = W_CLR;
                    sup_n         = SUP_PROG;
                    flg_n.repulse = 1'b0;
                    state_n       = S_P_SETUP;
                end
            end
            S_P_SETUP: state_n = S_P_PULSE;
            S_P_PULSE: begin
                if (expired) begin
                    state_n = S_P_HOLD;
                end
            end
            S_P_HOLD: begin
                if (flg.repulse) begin
                    flg_n.repulse = 1'b0;
                    adv           = 1'b1;
                end else if (last) begin
                    op          = W_CLR;
                    x_n         = '0;
                    flg_n.dirty = 1'b0;
                    state_n     = S_V_RD;
                end else begin
                    op      = W_INC;
                    state_n = S_P_SETUP;
                end
            end
            S_V_RD:  state_n = S_V_CMP;
            S_V_CMP: begin
                if (match) begin
                    adv = 1'b1;
                end else if (x_cnt == X_LIM) begin
                    fin_fail = 1'b1;
                end else begin
                    flg_n.dirty   = 1'b1;
                    flg_n.repulse = 1'b1;
                    state_n       = S_P_SETUP;
                end
            end
            S_F_RD:  state_n = S_F_CMP;
            S_F_CMP: begin
                if (!match) begin
                    fin_fail = 1'b1;
                end else if (last) begin
                    fin_pass = 1'b1;
                end else begin
                    op      = W_INC;
                    state_n = S_F_RD;
                end
            end
            default: state_n = S_IDLE;
        endcase

        // step to the next word of a verify pass
        if (adv) begin
            if (!last) begin
                op      = W_INC;
                state_n = S_V_RD;
            end else if (flg_n.dirty) begin
                op          = W_CLR;
                x_n         = x_cnt + 1'b1;
                flg_n.dirty = 1'b0;
                state_n     = S_V_RD;
            end else begin
                op      = W_CLR;
                sup_n   = SUP_READ;
                state_n = S_F_RD;
            end
        end

        if (fin_fail || fin_pass) begin
            state_n = S_DONE;
            sup_n   = SUP_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            sup       <= SUP_READ;
            flg       <= '0;
            x_cnt     <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail_addr <= '0;
        end else begin
            state <= state_n;
            sup   <= sup_n;
            flg   <= flg_n;
            x_cnt <= x_n;
            if (accept) begin
                done      <= 1'b0;
                pass      <= 1'b0;
                fail_addr <= '0;
            end else if (fin_fail) begin
                done      <= 1'b1;
                pass      <= 1'b0;
                fail_addr <= addr;
            end else if (fin_pass) begin
                done <= 1'b1;
                pass <= 1'b1;
            end
        end
    end

    assign dev_addr   = addr;
    assign img_addr   = addr;
    assign dev_wdata  = img_data;
    assign dev_pgm    = (state == S_P_PULSE);
    assign dev_rd     = (state == S_CC_RD) || (state == S_V_RD) || (state == S_F_RD);
    assign dev_supply = sup;
    assign busy       = (state != S_IDLE) && (state != S_DONE);
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int AW        = 4,
    parameter int PULSE_CYC = 10
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] dev_addr,
    input logic          dev_pgm,
    input logic          dev_rd,
    input logic [1:0]    dev_supply,
    input logic          busy,
    input logic          done,
    input logic          pass
);
    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !dev_pgm) begin
            hi_cnt <= 0;
        end else begin
            hi_cnt <= hi_cnt + 1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dev_pgm && !dev_rd));

    assert_pgm_supply_R4: assert property (@(posedge clk) disable iff (rst)
        dev_pgm |-> (dev_supply == 2'b10));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(dev_pgm && dev_rd));

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_pgm) |-> (hi_cnt == PULSE_CYC));

    assert_addr_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        dev_pgm |-> $stable(dev_addr));

    assert_addr_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_pgm) |-> $stable(dev_addr));

    assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .AW        (AW),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_addr   (dev_addr),
    .dev_pgm    (dev_pgm),
    .dev_rd     (dev_rd),
    .dev_supply (dev_supply),
    .busy       (busy),
    .done       (done),
    .pass       (pass)
);

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb;
    localparam int WORDS = 16;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int PW    = 10;          // 200 MHz * 50 ns
    localparam int LIM   = 2;
    localparam logic [AW-1:0] PAT_A = 4'h5;
    localparam logic [AW-1:0] PAT_B = 4'hA;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] img_addr, dev_addr, fail_addr;
    logic [DW-1:0] img_data, dev_wdata;
    logic [DW-1:0] dev_rdata = '0;
    logic          dev_pgm, dev_rd, busy, done, pass;
    logic [1:0]    dev_supply;

    always #2.5 clk = ~clk;

    otp_prog_seq #(
        .WORDS(WORDS), .DW(DW), .CLK_MHZ(200), .PULSE_NS(50),
        .RETRY_LIM(LIM), .CHK_CODE(16'h55AA)
    ) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .img_addr(img_addr), .img_data(img_data),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_pgm(dev_pgm), .dev_rd(dev_rd), .dev_rdata(dev_rdata),
        .dev_supply(dev_supply), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    int  need  [WORDS];
    bit  marg  [WORDS];
    int  given [WORDS];
    bit  cc_bad_a, cc_bad_b;
    bit  clr_model = 0;
    logic pg_q = 1'b0;

    function automatic logic [DW-1:0] img(input logic [AW-1:0] a);
        return 16'h2480 ^ {4{a}};
    endfunction

    assign img_data = img(img_addr);

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a,
                                                 input logic [1:0] s);
        if (s == 2'b01) begin
            if (a == PAT_A && !cc_bad_a) return 16'h55AA;
            if (a == PAT_B && !cc_bad_b) return 16'hAA55;
            return 16'hFFFF;
        end
        if (given[a] < need[a]) return 16'hFFFF;
        if (s == 2'b00 && marg[a]) return img(a) ^ 16'h0001;
        return img(a);
    endfunction

    always @(posedge clk) begin
        if (clr_model) begin
            for (int i = 0; i < WORDS; i++) given[i] <= 0;
            pg_q <= 1'b0;
        end else begin
            pg_q <= dev_pgm;
            if (dev_pgm && !pg_q) given[dev_addr] <= given[dev_addr] + 1;
            if (dev_rd) dev_rdata <= model_read(dev_addr, dev_supply);
        end
    end

    // ---------------- scoreboard ----------------
    int exp_q[$];
    int width = 0;
    logic [AW-1:0] paddr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dev_pgm) begin
                if (width == 0) begin
                    paddr = dev_addr;
                    chk(dev_supply == 2'b10, "R4", "supply in pulse", dev_supply, 2);
                end else if (dev_addr != paddr) begin
                    chk(0, "R6", "addr moved in pulse", dev_addr, paddr);
                end
                width++;
            end else if (width > 0) begin
                chk(width == PW, "R5", "pulse width", width, PW);
                chk(dev_addr == paddr, "R6", "addr after pulse", dev_addr, paddr);
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected pulse", paddr, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(paddr) == e, "R7", "pulse address", paddr, e);
                end
                width = 0;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic run_case(input string req, input bit probe);
        int  giv [WORDS];
        int  x;
        bit  failed, dirty;
        bit  e_pass;
        int  e_addr;
        int  cyc;

        exp_q.delete();
        failed = 0;
        e_addr = 0;
        if (cc_bad_a) begin
            failed = 1; e_addr = PAT_A;
        end else if (cc_bad_b) begin
            failed = 1; e_addr = PAT_B;
        end else begin
            for (int i = 0; i < WORDS; i++) begin exp_q.push_back(i); giv[i] = 1; end
            x = 0;
            forever begin
                dirty = 0;
                for (int i = 0; i < WORDS; i++) begin
                    if (giv[i] < need[i]) begin
                        if (x == LIM) begin failed = 1; e_addr = i; break; end
                        exp_q.push_back(i);
                        giv[i]++;
                        dirty = 1;
                    end
                end
                if (failed || !dirty) break;
                x++;
            end
            if (!failed) begin
                for (int i = 0; i < WORDS; i++) begin
                    if (marg[i]) begin failed = 1; e_addr = i; break; end
                end
            end
        end
        e_pass = !failed;

        clr_model = 1;
        @(negedge clk);
        clr_model = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy && !done, "R10", "busy after start", {busy, done}, 2'b10);
        if (probe) begin
            chk(dev_rd && dev_addr == PAT_A && dev_supply == 2'b01, "R2",
                "first contact read", {dev_rd, dev_supply, dev_addr}, {1'b1, 2'b01, PAT_A});
            @(negedge clk);
            @(negedge clk);
            chk(dev_rd && dev_addr == PAT_B && dev_supply == 2'b01, "R2",
                "second contact read", {dev_rd, dev_supply, dev_addr}, {1'b1, 2'b01, PAT_B});
        end
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R10", "run finished", done, 1);
        chk(pass == e_pass, req, "verdict", pass, e_pass);
        chk(int'(fail_addr) == (e_pass ? 0 : e_addr), req, "fail address",
            fail_addr, e_pass ? 0 : e_addr);
        chk(exp_q.size() == 0, req, "pulses left unseen", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(done && !busy && pass == e_pass && dev_supply == 2'b00, "R10",
            "result held", {done, busy, pass}, {1'b1, 1'b0, e_pass});
    endtask

    task automatic reset_model();
        for (int i = 0; i < WORDS; i++) begin need[i] = 1; marg[i] = 0; end
        cc_bad_a = 0;
        cc_bad_b = 0;
    endtask

    initial begin
        reset_model();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: idle state after reset
        chk(!busy && !done && !pass && !dev_pgm && !dev_rd, "R1", "idle outputs",
            {busy, done, pass, dev_pgm, dev_rd}, 0);
        chk(dev_supply == 2'b00 && fail_addr == 0, "R1", "idle supply/addr",
            {dev_supply, fail_addr}, 0);

        // R2, R4, R9: clean device passes
        run_case("R9", 1);

        // R7: weak words recover, including first and last address
        reset_model();
        need[3] = 2; need[7] = 3; need[15] = 2;
        run_case("R7", 0);
        reset_model();
        need[0] = 3; need[15] = 3;
        run_case("R7", 0);

        // R8: word needing too many pulses
        reset_model();
        need[2] = 2; need[5] = 4;
        run_case("R8", 0);

        // R3: each contact pattern failing
        reset_model();
        cc_bad_a = 1;
        run_case("R3", 0);
        reset_model();
        cc_bad_b = 1;
        run_case("R3", 0);

        // R9: marginal words fail only at read supply
        reset_model();
        marg[9] = 1; marg[12] = 1; need[4] = 2;
        run_case("R9", 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule